// File: doc/BRIEF.md
# UART FIFO Interrupt and Status Logic

This block produces the interrupt request, the interrupt identification code and the 8-bit line status word for a UART whose receive and transmit paths are buffered by FIFOs. The FIFO storage, the serial shifters and the bus decode sit outside it. They report to this block through plain inputs: the receive fill count, push and pop strobes with per-character error flags, the transmit-empty and shift-register-empty flags, and strobes for writes to the transmit FIFO and for reads of the identification and status values.

The receive interrupt compares the receive fill count with a programmable trigger level. It raises and drops by itself as the level crosses that threshold, with no acknowledge. A line-error interrupt and a transmit-empty interrupt complete the set of sources. When several sources are pending, a fixed priority picks the one that is reported. If every interrupt enable is cleared, the block runs in polled mode: the interrupt line stays low and software reads the status word. All outputs are registered, and each reflects the inputs sampled at the previous clock edge.

Top module: `uart_fifo_irq`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `lsr` = 8'h60 (transmit empty and idle, no data, no errors), `iid` = 4'b0001 (nothing pending) and `irq` = 0, whatever the other inputs are.
- R2: With `fifo_en` = 1 and `irq_en[0]` = 1, a receive interrupt is pending while `rx_count` is at or above the trigger level. `trig_sel` picks the level: 0 gives 1, 1 gives 16, 2 gives 32 and 3 gives 56 entries. The receive interrupt is reported as `iid` = 4'b0100.
- R3: The receive interrupt, and its code on `iid`, drop in the cycle after `rx_count` falls below the trigger level, with no acknowledge.
- R4: With `fifo_en` = 0, the receive interrupt is pending whenever `rx_count` is nonzero, whatever `trig_sel` is.
- R5: `lsr[0]` (data ready) is 1 exactly when `rx_count` is nonzero.
- R6: When `irq_en` is all zero (polled mode), `irq` is 0 and `iid` is 4'b0001, while every `lsr` bit keeps following its sources.
- R7: `lsr[4:1]` holds sticky error flags: bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break. They come from `rx_push_err[0..3]` on a push. An `lsr_rd` clears them, but an error pushed in the same cycle is kept. If `irq_en[2]` = 1 and any of these flags is set, a line-status interrupt is pending, reported as `iid` = 4'b0110.
- R8: `lsr[7]` is 1 while the receive FIFO holds at least one errored character. A push with any error flag set counts one such character. A pop with `rx_pop_err` = 1 removes one. `lsr_rd` does not clear this bit.
- R9: `lsr[5]` equals `tx_empty`. `lsr[6]` is 1 only when both `tx_empty` and `tsr_empty` are 1.
- R10: A transmit-empty interrupt becomes pending when `tx_empty` rises, or when `irq_en[1]` rises while `tx_empty` is 1. With `irq_en[1]` = 1 it is reported as `iid` = 4'b0010.
- R11: A pending transmit-empty interrupt is cleared by `tx_wr`, by `iid_rd` while `iid` shows 4'b0010, or by `tx_empty` going low.
- R12: When several sources are pending, `iid` reports line status first, then receive data, then transmit empty. `irq` is 1 exactly when at least one enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| irq_en | input | 3 | Interrupt enables: bit 0 receive, bit 1 transmit empty, bit 2 line status |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | 7 | Receive FIFO fill count (0 to 64) |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_push_err | input | 4 | Error flags of the pushed character: overrun, parity, framing, break |
| rx_pop | input | 1 | A character left the receive FIFO |
| rx_pop_err | input | 1 | The popped character carried an error |
| tx_empty | input | 1 | Transmit FIFO empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| tx_wr | input | 1 | Write into the transmit FIFO |
| iid_rd | input | 1 | Read of the identification value |
| lsr_rd | input | 1 | Read of the line status word |
| irq | output | 1 | Interrupt request |
| iid | output | 4 | Interrupt identification code |
| lsr | output | 8 | Line status word |

## Verification
The assertions take for granted that `rx_count` never goes above the FIFO depth. They also assume `rx_pop_err` is raised only for a character that was counted as errored, and that `tx_wr` comes only with a transmit FIFO that is no longer empty on the next cycle, or is immediately refilled. The stimulus keeps `rx_count` between 0 and 64. It pops errored characters only after pushing them, and it drives the strobes as single-cycle pulses set up after a falling edge. The checks against the trigger level always hold the enables and the trigger select steady across the cycle they observe.

// File: rtl/uirq_pkg.sv
`timescale 1ns/1ps
package uirq_pkg;

    typedef enum logic [3:0] {
        IID_NONE = 4'b0001,
        IID_TXE  = 4'b0010,
        IID_RXD  = 4'b0100,
        IID_LINE = 4'b0110
    } iid_e;

    typedef enum logic [1:0] {
        TRIG_ONE  = 2'd0,
        TRIG_QTR  = 2'd1,
        TRIG_HALF = 2'd2,
        TRIG_NEAR = 2'd3
    } trig_e;

    // Field order fixed by software decoding of the status word.
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } err_t;

    typedef struct packed {
        logic fifo_err;
        logic tx_idle;
        logic tx_empty;
        err_t err;
        logic data_rdy;
    } lsr_t;

    localparam int NSRC = 3;           // 0: line, 1: receive, 2: transmit
    localparam lsr_t LSR_RESET = '{fifo_err: 1'b0, tx_idle: 1'b1, tx_empty: 1'b1,
                                   err: '0, data_rdy: 1'b0};

    function automatic int unsigned trig_level(input trig_e sel, input int unsigned depth);
        case (sel)
            TRIG_ONE:  return 1;
            TRIG_QTR:  return depth / 4;
            TRIG_HALF: return depth / 2;
            default:   return depth - depth / 8;
        endcase
    endfunction

    function automatic iid_e src_code(input int idx);
        case (idx)
            0:       return IID_LINE;
            1:       return IID_RXD;
            default: return IID_TXE;
        endcase
    endfunction

endpackage

// File: rtl/uirq_rx_level.sv
`timescale 1ns/1ps
module uirq_rx_level
    import uirq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             fifo_en,
    input  trig_e            trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    output logic             rx_hit,
    output logic             data_rdy
);
    logic [CNT_W-1:0] level;

    always_comb begin
        level    = CNT_W'(trig_level(trig_sel, DEPTH));
        data_rdy = (rx_count != '0);
        // Without FIFO mode a single character is the threshold.
        rx_hit   = fifo_en ? (rx_count >= level) : data_rdy;
    end
endmodule

// File: rtl/uirq_line_err.sv
`timescale 1ns/1ps
module uirq_line_err
    import uirq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_push,
    input  err_t push_err,
    input  logic rx_pop,
    input  logic rx_pop_err,
    input  logic lsr_rd,
    output err_t err_nxt,
    output logic bad_nxt
);
    err_t             err_q;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             inc, dec;

    always_comb begin
        err_nxt = lsr_rd ? '0 : err_q;
        if (rx_push) err_nxt = err_nxt | push_err;

        inc = rx_push && (push_err != '0) && (cnt_q < CNT_W'(DEPTH));
        dec = rx_pop && rx_pop_err && (cnt_q != '0);
        cnt_nxt = cnt_q;
        if (inc && !dec)      cnt_nxt = cnt_q + 1'b1;
        else if (dec && !inc) cnt_nxt = cnt_q - 1'b1;
        bad_nxt = (cnt_nxt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
            cnt_q <= '0;
        end else begin
            err_q <= err_nxt;
            cnt_q <= cnt_nxt;
        end
    end
endmodule

// File: rtl/uirq_tx_empty.sv
`timescale 1ns/1ps
module uirq_tx_empty (
    input  logic clk,
    input  logic rst,
    input  logic tx_empty,
    input  logic en_bit,
    input  logic tx_wr,
    input  logic iid_rd,
    input  logic iid_is_tx,
    output logic thre_nxt
);
    logic thre_q, txe_d, en_d;
    logic arm, drop;

    always_comb begin
        arm      = tx_empty && (!txe_d || (en_bit && !en_d));
        drop     = tx_wr || (iid_rd && iid_is_tx);
        thre_nxt = tx_empty && !drop && (arm || thre_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thre_q <= 1'b0;
            txe_d  <= 1'b1;
            en_d   <= 1'b0;
        end else begin
            thre_q <= thre_nxt;
            txe_d  <= tx_empty;
            en_d   <= en_bit;
        end
    end
endmodule

// File: rtl/uirq_prio.sv
`timescale 1ns/1ps
module uirq_prio
    import uirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] pend,
    output iid_e         code,
    output logic         any
);
    always_comb begin
        code = IID_NONE;
        // Lowest index has highest priority, so it is applied last.
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) code = src_code(i);
        end
        any = |pend;
    end
endmodule

// File: rtl/uart_fifo_irq.sv
`timescale 1ns/1ps
module uart_fifo_irq
    import uirq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic [2:0]       irq_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic [3:0]       rx_push_err,
    input  logic             rx_pop,
    input  logic             rx_pop_err,
    input  logic             tx_empty,
    input  logic             tsr_empty,
    input  logic             tx_wr,
    input  logic             iid_rd,
    input  logic             lsr_rd,
    output logic             irq,
    output logic [3:0]       iid,
    output logic [7:0]       lsr
);
    logic            rx_hit, data_rdy, bad_nxt, thre_nxt, any_pend;
    err_t            err_nxt;
    iid_e            code_nxt, iid_q;
    lsr_t            lsr_nxt, lsr_q;
    logic            irq_q;
    logic [NSRC-1:0] pend;

    uirq_rx_level #(.DEPTH(DEPTH)) u_rx (
        .fifo_en  (fifo_en),
        .trig_sel (trig_e'(trig_sel)),
        .rx_count (rx_count),
        .rx_hit   (rx_hit),
        .data_rdy (data_rdy)
    );

    uirq_line_err #(.DEPTH(DEPTH)) u_err (
        .clk        (clk),
        .rst        (rst),
        .rx_push    (rx_push),
        .push_err   (err_t'(rx_push_err)),
        .rx_pop     (rx_pop),
        .rx_pop_err (rx_pop_err),
        .lsr_rd     (lsr_rd),
        .err_nxt    (err_nxt),
        .bad_nxt    (bad_nxt)
    );

    uirq_tx_empty u_tx (
        .clk       (clk),
        .rst       (rst),
        .tx_empty  (tx_empty),
        .en_bit    (irq_en[1]),
        .tx_wr     (tx_wr),
        .iid_rd    (iid_rd),
        .iid_is_tx (iid_q == IID_TXE),
        .thre_nxt  (thre_nxt)
    );

    always_comb begin
        pend[0] = irq_en[2] && (err_nxt != '0);
        pend[1] = irq_en[0] && rx_hit;
        pend[2] = irq_en[1] && thre_nxt;
    end

    uirq_prio #(.N(NSRC)) u_prio (
        .pend (pend),
        .code (code_nxt),
        .any  (any_pend)
    );

    always_comb begin
        lsr_nxt = '{fifo_err: bad_nxt,
                    tx_idle:  tx_empty && tsr_empty,
                    tx_empty: tx_empty,
                    err:      err_nxt,
                    data_rdy: data_rdy};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lsr_q <= LSR_RESET;
            iid_q <= IID_NONE;
            irq_q <= 1'b0;
        end else begin
            lsr_q <= lsr_nxt;
            iid_q <= code_nxt;
            irq_q <= any_pend;
        end
    end

    assign irq = irq_q;
    assign iid = iid_q;
    assign lsr = lsr_q;
endmodule

// File: rtl/uart_fifo_irq_chk.sv
`timescale 1ns/1ps
module uart_fifo_irq_chk
    import uirq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic [2:0]       irq_en,
    input logic [1:0]       trig_sel,
    input logic [CNT_W-1:0] rx_count,
    input logic             tx_empty,
    input logic             tsr_empty,
    input logic             tx_wr,
    input logic             irq,
    input logic [3:0]       iid,
    input logic [7:0]       lsr
);
    logic [CNT_W-1:0] lvl;
    assign lvl = CNT_W'(trig_level(trig_e'(trig_sel), DEPTH));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (lsr == 8'h60 && !irq && iid == IID_NONE));

    // R2
    rx_trigger_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && irq_en == 3'b001 && rx_count >= lvl) |=> (irq && iid == IID_RXD));

    // R3
    rx_trigger_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && irq_en == 3'b001 && rx_count < lvl) |=> (!irq && iid == IID_NONE));

    // R5
    data_ready_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lsr[0] == ($past(rx_count) != '0)));

    // R6
    polled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_en == 3'b000) |=> (!irq && iid == IID_NONE));

    // R9
    tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && tsr_empty) |=> (lsr[6] && lsr[5]));

    // R9
    tx_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_empty |=> (!lsr[5] && !lsr[6]));

    // R11
    tx_write_clears_chk: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> (iid != IID_TXE));

    // R12
    irq_matches_code_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (iid != IID_NONE));
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fifo_en   (fifo_en),
    .irq_en    (irq_en),
    .trig_sel  (trig_sel),
    .rx_count  (rx_count),
    .tx_empty  (tx_empty),
    .tsr_empty (tsr_empty),
    .tx_wr     (tx_wr),
    .irq       (irq),
    .iid       (iid),
    .lsr       (lsr)
);

// File: tb/uart_fifo_irq_bench.sv
`timescale 1ns/1ps
module uart_fifo_irq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b1;
    logic [2:0] irq_en = 3'b000;
    logic [1:0] trig_sel = 2'd0;
    logic [6:0] rx_count = 7'd5;
    logic       rx_push = 1'b0;
    logic [3:0] rx_push_err = 4'h0;
    logic       rx_pop = 1'b0;
    logic       rx_pop_err = 1'b0;
    logic       tx_empty = 1'b0;
    logic       tsr_empty = 1'b1;
    logic       tx_wr = 1'b0;
    logic       iid_rd = 1'b0;
    logic       lsr_rd = 1'b0;
    logic       irq;
    logic [3:0] iid;
    logic [7:0] lsr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [12:0] exp_q[$];
    string       tag_q[$];

    // Reference state, derived from the requirements.
    logic [3:0] m_err = 4'h0;
    int         m_ecnt = 0;
    bit         m_thre = 1'b0;
    bit         m_txe_p = 1'b1;
    bit         m_en1_p = 1'b0;
    logic [3:0] m_iid = 4'h1;

    always #5 clk = ~clk;

    uart_fifo_irq u_uart_fifo_irq (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .irq_en(irq_en),
        .trig_sel(trig_sel), .rx_count(rx_count), .rx_push(rx_push),
        .rx_push_err(rx_push_err), .rx_pop(rx_pop), .rx_pop_err(rx_pop_err),
        .tx_empty(tx_empty), .tsr_empty(tsr_empty), .tx_wr(tx_wr),
        .iid_rd(iid_rd), .lsr_rd(lsr_rd), .irq(irq), .iid(iid), .lsr(lsr)
    );

    function automatic int lvl_of(input logic [1:0] s);
        case (s)
            2'd0:    return 1;
            2'd1:    return 16;
            2'd2:    return 32;
            default: return 56;
        endcase
    endfunction

    // Driver: predicts the outputs for the current inputs, queues them, then
    // lets one clock edge pass and drops the single-cycle strobes.
    task automatic cyc(input string tag);
        logic [3:0] iid_x;
        logic       irq_x;
        logic [7:0] lsr_x;
        bit         rxh, ls, rx, tx, arm, drop, inc, dec;
        if (rst) begin
            m_err = 4'h0; m_ecnt = 0; m_thre = 1'b0; m_txe_p = 1'b1; m_en1_p = 1'b0;
            iid_x = 4'h1; irq_x = 1'b0; lsr_x = 8'h60;
        end else begin
            m_err = (lsr_rd ? 4'h0 : m_err) | (rx_push ? rx_push_err : 4'h0);
            inc = rx_push && (rx_push_err != 4'h0) && (m_ecnt < 64);
            dec = rx_pop && rx_pop_err && (m_ecnt > 0);
            m_ecnt = m_ecnt + (inc ? 1 : 0) - (dec ? 1 : 0);
            arm  = tx_empty && (!m_txe_p || (irq_en[1] && !m_en1_p));
            drop = tx_wr || (iid_rd && m_iid == 4'h2);
            m_thre = tx_empty && !drop && (arm || m_thre);
            m_txe_p = tx_empty;
            m_en1_p = irq_en[1];
            rxh = fifo_en ? (int'(rx_count) >= lvl_of(trig_sel)) : (rx_count != 0);
            ls = irq_en[2] && (m_err != 4'h0);
            rx = irq_en[0] && rxh;
            tx = irq_en[1] && m_thre;
            iid_x = ls ? 4'h6 : rx ? 4'h4 : tx ? 4'h2 : 4'h1;
            irq_x = ls || rx || tx;
            lsr_x = {m_ecnt != 0, tx_empty && tsr_empty, tx_empty, m_err, rx_count != 0};
        end
        m_iid = iid_x;
        exp_q.push_back({irq_x, iid_x, lsr_x});
        tag_q.push_back(tag);
        @(negedge clk);
        rx_push = 1'b0; rx_push_err = 4'h0; rx_pop = 1'b0; rx_pop_err = 1'b0;
        tx_wr = 1'b0; iid_rd = 1'b0; lsr_rd = 1'b0;
    endtask

    // Monitor: compares each registered result just after the edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [12:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({irq, iid, lsr} !== e) begin
                errors++;
                $display("FAIL %s: irq=%0b iid=%h lsr=%h expected irq=%0b iid=%h lsr=%h",
                         t, irq, iid, lsr, e[12], e[11:8], e[7:0]);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rx_push = 1'b1; rx_push_err = 4'hF; tx_wr = 1'b1;
        cyc("R1 reset with busy inputs");
        cyc("R1 reset held");
        rst = 1'b0;
        rx_count = 7'd0; tx_empty = 1'b1; tsr_empty = 1'b1;
        cyc("R9 idle after reset");

        // R2 / R3: trigger crossing for each select value
        irq_en = 3'b001;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            rx_count = 7'(lvl_of(trig_sel) - 1); cyc("R3 below trigger");
            rx_count = 7'(lvl_of(trig_sel));     cyc("R2 at trigger");
            rx_count = 7'(lvl_of(trig_sel) + 1); cyc("R2 above trigger");
            rx_count = 7'(lvl_of(trig_sel) - 1); cyc("R3 drop below trigger");
        end

        // R4: non-FIFO mode ignores the trigger select
        fifo_en = 1'b0; trig_sel = 2'd3;
        rx_count = 7'd1; cyc("R4 single char irq");
        rx_count = 7'd0; cyc("R4 empty no irq");
        fifo_en = 1'b1;

        // R5: data ready follows occupancy
        irq_en = 3'b000;
        rx_count = 7'd1;  cyc("R5 first char");
        rx_count = 7'd2;  cyc("R5 two chars");
        rx_count = 7'd0;  cyc("R5 drained");

        // R6: polled mode with every source active
        rx_count = 7'd60; rx_push = 1'b1; rx_push_err = 4'b0101; cyc("R6 polled error push");
        tx_empty = 1'b0;  cyc("R6 polled tx busy");
        tx_empty = 1'b1;  cyc("R6 polled tx empty");
        lsr_rd = 1'b1;    cyc("R6 polled status read");

        // R7 / R8: each error type, line interrupt, sticky bits
        irq_en = 3'b100; rx_count = 7'd3;
        for (int b = 0; b < 4; b++) begin
            rx_push = 1'b1; rx_push_err = 4'(1 << b); cyc("R7 error flag raised");
            cyc("R7 error flag sticky");
            lsr_rd = 1'b1; cyc("R8 read clears flags keeps fifo error");
        end
        lsr_rd = 1'b1; rx_push = 1'b1; rx_push_err = 4'b1000; cyc("R7 push wins over read");
        lsr_rd = 1'b1; cyc("R7 read clears");
        rx_push = 1'b1; rx_push_err = 4'h0; cyc("R8 clean push");
        for (int k = 0; k < 6; k++) begin
            rx_pop = 1'b1; rx_pop_err = 1'b1; cyc("R8 errored pop");
        end
        rx_pop = 1'b1; cyc("R8 clean pop");

        // R10 / R11: transmit empty interrupt
        irq_en = 3'b010; rx_count = 7'd0;
        tx_empty = 1'b0; tx_wr = 1'b1; cyc("R11 write makes busy");
        tx_empty = 1'b1; cyc("R10 fifo drained");
        cyc("R10 pending held");
        iid_rd = 1'b1;   cyc("R11 id read clears");
        cyc("R11 stays cleared");
        tx_empty = 1'b0; cyc("R9 busy");
        tx_empty = 1'b1; tsr_empty = 1'b0; cyc("R10 drained shifter busy");
        tsr_empty = 1'b1; cyc("R9 fully idle");
        tx_wr = 1'b1;    cyc("R11 write clears");
        irq_en = 3'b000; cyc("R10 enable off");
        irq_en = 3'b010; cyc("R10 enable rise while empty");
        tx_empty = 1'b0; cyc("R11 busy clears");

        // R12: priority among simultaneous sources
        tx_empty = 1'b1; irq_en = 3'b111; trig_sel = 2'd3;
        rx_count = 7'd60; rx_push = 1'b1; rx_push_err = 4'b0001; cyc("R12 all pending line first");
        lsr_rd = 1'b1;  cyc("R12 receive next");
        rx_count = 7'd10; cyc("R12 transmit last");
        iid_rd = 1'b1;  cyc("R12 nothing left");
        rx_pop = 1'b1; rx_pop_err = 1'b1; cyc("R8 final errored pop");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule